// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is a bus slave for an 8-bit host processor. It gives the host access to four identical banks of channel registers. Two strap inputs select the bus flavour. The first picks the control pin convention: separate read and write strobes, or a data strobe with a read/write level. The second picks the address path: a shared address/data bus with an address latch strobe, or a separate address bus. Two upper address pins choose the channel bank, and one active-low chip select gates every access.

All pins are sampled on the system clock. Strobe edges are found in the clock domain, so the bus flavour only changes the decode and never the clocking. A write takes effect after the write strobe ends. Read data is driven, with an output enable, while the host holds a selected read. Each bank holds configuration bytes, a sticky event register with its interrupt mask, and two constant identification bytes. An active-low interrupt combines the enabled events of all banks. A rising edge on a hardware reset input clears all writable state.

Top module: `hbus_regport`

## Requirements
- R1: Bus flavour. With `bus_type`=0, an access is a read while `rd_ds` is low and a write while `wr_rw` is low. With `bus_type`=1, the data strobe `rd_ds` is active low when `mux_sel`=1 and active high when `mux_sel`=0. While the strobe is active, `wr_rw`=1 means read and `wr_rw`=0 means write.
- R2: Offset. With `mux_sel`=0 the 8-bit offset is {`ale_a7`, `addr_lo`}. With `mux_sel`=1 the offset is the `ad_in` value captured when sampled `ale_a7` rises, and `addr_lo` is ignored.
- R3: `addr_hi` selects the bank (0..3) of each access. Banks hold independent contents.
- R4: A write updates its register at the clock edge after the first sample in which the write is no longer active. It uses the offset, bank and `ad_in` data of the last active write sample.
- R5: Two edges after a sample with an active read, `ad_oe`=1 and `ad_out` carries the addressed register. Otherwise `ad_oe`=0 and `ad_out`=0.
- R6: Per-bank map. Offsets 0x00–0x0F are read/write configuration bytes. 0x80 is the event register, 0x81 is the interrupt mask, 0x82 is the device ID and 0x83 is the revision. Every other offset reads 0 and ignores writes.
- R7: The ID byte (0x82) reads 0xA5 and the revision byte (0x83) reads 0x03. Writes to either have no effect.
- R8: A high bit on `stat_evt[8*b+i]` at a clock edge sets bit i of bank b's event register. The bit stays set until a write of 1 to that bit position at offset 0x80. When a set and a clear fall on the same edge, the set wins.
- R9: `irq_n` is 0 one edge after any bank has an event bit set whose mask bit is 1, and is 1 otherwise.
- R10: A sampled low-to-high transition on `hw_reset` clears all configuration bytes, masks and event registers at the next edge. Holding the pin high does not block later writes.
- R11: With `cs_n` high, no write is committed and `ad_oe` stays 0.
- R12: While `rst` is high, all registers clear, `ad_oe`=0, `ad_out`=0 and `irq_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_sel | input | 1 | Strap: 1 = shared address/data bus |
| bus_type | input | 1 | Strap: 1 = data strobe with read/write level |
| cs_n | input | 1 | Active-low chip select |
| ale_a7 | input | 1 | Address latch strobe (shared bus) or offset bit 7 |
| rd_ds | input | 1 | Read strobe or data strobe |
| wr_rw | input | 1 | Write strobe or read/write level |
| addr_lo | input | 7 | Offset bits 6:0 for the separate bus |
| addr_hi | input | 2 | Bank select |
| ad_in | input | 8 | Incoming address/data byte |
| hw_reset | input | 1 | Hardware reset, rising-edge active |
| stat_evt | input | 32 | Event pulses, 8 per bank |
| ad_out | output | 8 | Read data |
| ad_oe | output | 1 | Read data output enable |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case is a host that changes bus flavour while the registers are live. The decode, the address source and the strobe polarity then all change, and an access under the wrong convention must not disturb the contents. The stimulus runs the same write and read sequence in all four strap combinations against every bank, with the offset pins set to junk in shared-bus mode. A cycle-level model follows the pins on every clock. This exposes any latch, polarity or commit-timing slip at the moment it occurs, and not only in the final read-back.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    BUS_SPLIT_SEP = 2'b00,
    BUS_SPLIT_MUX = 2'b01,
    BUS_LEVEL_SEP = 2'b10,
    BUS_LEVEL_MUX = 2'b11
  } bus_flavour_t;

  localparam int STAT_OFF = 8'h80;
  localparam int MASK_OFF = 8'h81;
  localparam int ID_OFF   = 8'h82;
  localparam int REV_OFF  = 8'h83;
endpackage

// File: rtl/hbus_strobe_decode.sv
module hbus_strobe_decode #(
  parameter int DW     = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mux_sel,
  input  logic              bus_type,
  input  logic              cs_n,
  input  logic              ale_a7,
  input  logic              rd_ds,
  input  logic              wr_rw,
  input  logic [DW-2:0]     addr_lo,
  input  logic [BANK_W-1:0] addr_hi,
  input  logic [DW-1:0]     ad_in,
  input  logic              hw_reset,
  output logic              rd_act,
  output logic [DW-1:0]     rd_off,
  output logic [BANK_W-1:0] rd_bank,
  output logic              commit,
  output logic [DW-1:0]     cm_off,
  output logic [DW-1:0]     cm_data,
  output logic [BANK_W-1:0] cm_bank,
  output logic              clr_all
);
  import hbus_pkg::*;

  logic              s_mux, s_bts, s_cs_n, s_ale, s_rd, s_wr, s_hr;
  logic [DW-2:0]     s_alo;
  logic [BANK_W-1:0] s_ahi;
  logic [DW-1:0]     s_ad;
  logic              p_ale, p_wr_act, p_hr;
  logic [DW-1:0]     adr_latch;
  logic              strobe_rd, strobe_wr, wr_act;
  logic [DW-1:0]     cur_off;
  bus_flavour_t      flavour;

  // input sampling stage
  always_ff @(posedge clk) begin
    if (rst) begin
      s_mux  <= 1'b0;
      s_bts  <= 1'b0;
      s_cs_n <= 1'b1;
      s_ale  <= 1'b0;
      s_rd   <= 1'b1;
      s_wr   <= 1'b1;
      s_hr   <= 1'b0;
      s_alo  <= '0;
      s_ahi  <= '0;
      s_ad   <= '0;
    end else begin
      s_mux  <= mux_sel;
      s_bts  <= bus_type;
      s_cs_n <= cs_n;
      s_ale  <= ale_a7;
      s_rd   <= rd_ds;
      s_wr   <= wr_rw;
      s_hr   <= hw_reset;
      s_alo  <= addr_lo;
      s_ahi  <= addr_hi;
      s_ad   <= ad_in;
    end
  end

  assign flavour = bus_flavour_t'({s_bts, s_mux});

  always_comb begin
    strobe_rd = 1'b0;
    strobe_wr = 1'b0;
    unique case (flavour)
      BUS_SPLIT_SEP, BUS_SPLIT_MUX: begin
        strobe_rd = !s_rd;
        strobe_wr = !s_wr;
      end
      BUS_LEVEL_SEP: begin
        strobe_rd = s_rd && s_wr;
        strobe_wr = s_rd && !s_wr;
      end
      BUS_LEVEL_MUX: begin
        strobe_rd = !s_rd && s_wr;
        strobe_wr = !s_rd && !s_wr;
      end
    endcase
  end

  assign rd_act  = !s_cs_n && strobe_rd;
  assign wr_act  = !s_cs_n && strobe_wr;
  assign cur_off = s_mux ? adr_latch : {s_ale, s_alo};
  assign rd_off  = cur_off;
  assign rd_bank = s_ahi;

  // edge history, address latch and write capture
  always_ff @(posedge clk) begin
    if (rst) begin
      p_ale     <= 1'b0;
      p_wr_act  <= 1'b0;
      p_hr      <= 1'b0;
      adr_latch <= '0;
      cm_off    <= '0;
      cm_data   <= '0;
      cm_bank   <= '0;
    end else begin
      p_ale    <= s_ale;
      p_wr_act <= wr_act;
      p_hr     <= s_hr;
      if (s_mux && s_ale && !p_ale)
        adr_latch <= s_ad;
      if (wr_act) begin
        cm_off  <= cur_off;
        cm_data <= s_ad;
        cm_bank <= s_ahi;
      end
    end
  end

  assign commit  = p_wr_act && !wr_act;
  assign clr_all = s_hr && !p_hr;

  // R4
  one_commit_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R10
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> !clr_all);
endmodule

// File: rtl/hbus_chan_regs.sv
module hbus_chan_regs #(
  parameter int          DW        = 8,
  parameter int          CFG_DEPTH = 16,
  parameter logic [7:0]  DEV_ID    = 8'hA5,
  parameter logic [7:0]  REV_ID    = 8'h03
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_off,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] evt,
  input  logic [DW-1:0] rd_off,
  output logic [DW-1:0] rd_data,
  output logic          irq_req
);
  localparam int            CFG_AW  = $clog2(CFG_DEPTH);
  localparam logic [DW-1:0] CFG_LIM = DW'(CFG_DEPTH);
  localparam logic [DW-1:0] STAT_A  = DW'(hbus_pkg::STAT_OFF);
  localparam logic [DW-1:0] MASK_A  = DW'(hbus_pkg::MASK_OFF);
  localparam logic [DW-1:0] ID_A    = DW'(hbus_pkg::ID_OFF);
  localparam logic [DW-1:0] REV_A   = DW'(hbus_pkg::REV_OFF);

  logic [DW-1:0] cfg_mem [CFG_DEPTH];
  logic [DW-1:0] stat, mask;
  logic          cfg_wr, stat_wr, mask_wr;

  assign cfg_wr  = wr_en && (wr_off < CFG_LIM);
  assign stat_wr = wr_en && (wr_off == STAT_A);
  assign mask_wr = wr_en && (wr_off == MASK_A);

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      for (int i = 0; i < CFG_DEPTH; i++) cfg_mem[i] <= '0;
    end else if (cfg_wr) begin
      cfg_mem[wr_off[CFG_AW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      stat <= '0;
      mask <= '0;
    end else begin
      if (stat_wr) stat <= (stat & ~wr_data) | evt;
      else         stat <= stat | evt;
      if (mask_wr) mask <= wr_data;
    end
  end

  always_comb begin
    if (rd_off < CFG_LIM) rd_data = cfg_mem[rd_off[CFG_AW-1:0]];
    else if (rd_off == STAT_A) rd_data = stat;
    else if (rd_off == MASK_A) rd_data = mask;
    else if (rd_off == ID_A)   rd_data = DW'(DEV_ID);
    else if (rd_off == REV_A)  rd_data = DW'(REV_ID);
    else                       rd_data = '0;
  end

  assign irq_req = |(stat & mask);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_all) && !$past(stat_wr)) |-> ((stat & $past(stat)) == $past(stat)));

  // R8
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_all) |-> ((stat & $past(evt)) == $past(evt)));

  // R10
  hw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_all) |-> (stat == '0 && mask == '0));
endmodule

// File: rtl/hbus_regport.sv
module hbus_regport #(
  parameter int         DW        = 8,
  parameter int         BANK_W    = 2,
  parameter int         CFG_DEPTH = 16,
  parameter logic [7:0] DEV_ID    = 8'hA5,
  parameter logic [7:0] REV_ID    = 8'h03
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mux_sel,
  input  logic                       bus_type,
  input  logic                       cs_n,
  input  logic                       ale_a7,
  input  logic                       rd_ds,
  input  logic                       wr_rw,
  input  logic [DW-2:0]              addr_lo,
  input  logic [BANK_W-1:0]          addr_hi,
  input  logic [DW-1:0]              ad_in,
  input  logic                       hw_reset,
  input  logic [(1<<BANK_W)*DW-1:0]  stat_evt,
  output logic [DW-1:0]              ad_out,
  output logic                       ad_oe,
  output logic                       irq_n
);
  localparam int NCH = 1 << BANK_W;

  logic              rd_act, commit, clr_all;
  logic [DW-1:0]     rd_off, cm_off, cm_data;
  logic [BANK_W-1:0] rd_bank, cm_bank;
  logic [DW-1:0]     chan_rd [NCH];
  logic [NCH-1:0]    irq_vec;

  hbus_strobe_decode #(.DW(DW), .BANK_W(BANK_W)) u_decode (
    .clk(clk), .rst(rst), .mux_sel(mux_sel), .bus_type(bus_type),
    .cs_n(cs_n), .ale_a7(ale_a7), .rd_ds(rd_ds), .wr_rw(wr_rw),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .ad_in(ad_in),
    .hw_reset(hw_reset), .rd_act(rd_act), .rd_off(rd_off),
    .rd_bank(rd_bank), .commit(commit), .cm_off(cm_off),
    .cm_data(cm_data), .cm_bank(cm_bank), .clr_all(clr_all)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    hbus_chan_regs #(
      .DW(DW), .CFG_DEPTH(CFG_DEPTH), .DEV_ID(DEV_ID), .REV_ID(REV_ID)
    ) u_regs (
      .clk(clk), .rst(rst), .clr_all(clr_all),
      .wr_en(commit && (cm_bank == BANK_W'(ch))),
      .wr_off(cm_off), .wr_data(cm_data),
      .evt(stat_evt[ch*DW +: DW]),
      .rd_off(rd_off), .rd_data(chan_rd[ch]),
      .irq_req(irq_vec[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_oe  <= 1'b0;
      ad_out <= '0;
      irq_n  <= 1'b1;
    end else begin
      ad_oe  <= rd_act;
      ad_out <= rd_act ? chan_rd[rd_bank] : '0;
      irq_n  <= !(|irq_vec);
    end
  end

  // R5
  oe_data_chk: assert property (@(posedge clk) disable iff (rst)
    !ad_oe |-> (ad_out == '0));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(|irq_vec));
endmodule

// File: tb/test_hbus_regport.sv
`timescale 1ns/1ps
module test_hbus_regport;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mux_sel = 0, bus_type = 0, cs_n = 1, ale_a7 = 0, rd_ds = 1, wr_rw = 1;
  logic [6:0] addr_lo = 0;
  logic [1:0] addr_hi = 0;
  logic [7:0] ad_in = 0;
  logic hw_reset = 0;
  logic [31:0] stat_evt = 0;
  logic [7:0] ad_out;
  logic ad_oe, irq_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hbus_regport i_hbus_regport (
    .clk(clk), .rst(rst), .mux_sel(mux_sel), .bus_type(bus_type),
    .cs_n(cs_n), .ale_a7(ale_a7), .rd_ds(rd_ds), .wr_rw(wr_rw),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .ad_in(ad_in),
    .hw_reset(hw_reset), .stat_evt(stat_evt), .ad_out(ad_out),
    .ad_oe(ad_oe), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] cfgm [4][16];
  logic [7:0] mstat [4];
  logic [7:0] mmask [4];
  logic ms_mux, ms_bts, ms_csn, ms_ale, ms_rd, ms_wr, ms_hr;
  logic [6:0] ms_alo;
  logic [1:0] ms_ahi;
  logic [7:0] ms_ad;
  logic mp_ale, mp_wr, mp_hr;
  logic [7:0] mlatch, mc_off, mc_dat;
  logic [1:0] mc_bank;
  logic exp_oe, exp_irq, mvalid = 0;
  logic [7:0] exp_out;

  function automatic logic [7:0] mread(input logic [1:0] b, input logic [7:0] o);
    if (o < 8'h10) return cfgm[b][o[3:0]];
    case (o)
      8'h80: return mstat[b];
      8'h81: return mmask[b];
      8'h82: return 8'hA5;
      8'h83: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic m_rd, m_wr, any, commit_m, clr_m;
    logic [7:0] m_off, ev;
    if (!ms_bts) begin
      m_rd = !ms_csn && !ms_rd;
      m_wr = !ms_csn && !ms_wr;
    end else begin
      m_rd = !ms_csn && (ms_mux ? !ms_rd : ms_rd) && ms_wr;
      m_wr = !ms_csn && (ms_mux ? !ms_rd : ms_rd) && !ms_wr;
    end
    m_off = ms_mux ? mlatch : {ms_ale, ms_alo};
    if (rst) begin
      exp_oe = 0; exp_out = 0; exp_irq = 1;
      for (int b = 0; b < 4; b++) begin
        mstat[b] = 0; mmask[b] = 0;
        for (int r = 0; r < 16; r++) cfgm[b][r] = 0;
      end
      ms_mux = 0; ms_bts = 0; ms_csn = 1; ms_ale = 0; ms_rd = 1; ms_wr = 1;
      ms_hr = 0; ms_alo = 0; ms_ahi = 0; ms_ad = 0;
      mp_ale = 0; mp_wr = 0; mp_hr = 0; mlatch = 0;
      mc_off = 0; mc_dat = 0; mc_bank = 0;
    end else begin
      exp_oe  = m_rd;
      exp_out = m_rd ? mread(ms_ahi, m_off) : 8'h00;
      any = 0;
      for (int b = 0; b < 4; b++) if ((mstat[b] & mmask[b]) != 0) any = 1;
      exp_irq = !any;
      commit_m = mp_wr && !m_wr;
      clr_m = ms_hr && !mp_hr;
      for (int b = 0; b < 4; b++) begin
        ev = stat_evt[b*8 +: 8];
        if (clr_m) begin
          mstat[b] = 0; mmask[b] = 0;
          for (int r = 0; r < 16; r++) cfgm[b][r] = 0;
        end else begin
          if (commit_m && mc_bank == 2'(b)) begin
            if (mc_off < 8'h10) cfgm[b][mc_off[3:0]] = mc_dat;
            if (mc_off == 8'h81) mmask[b] = mc_dat;
            if (mc_off == 8'h80) mstat[b] = mstat[b] & ~mc_dat;
          end
          mstat[b] = mstat[b] | ev;
        end
      end
      if (m_wr) begin mc_off = m_off; mc_dat = ms_ad; mc_bank = ms_ahi; end
      if (ms_mux && ms_ale && !mp_ale) mlatch = ms_ad;
      mp_ale = ms_ale; mp_wr = m_wr; mp_hr = ms_hr;
      ms_mux = mux_sel; ms_bts = bus_type; ms_csn = cs_n; ms_ale = ale_a7;
      ms_rd = rd_ds; ms_wr = wr_rw; ms_hr = hw_reset; ms_alo = addr_lo;
      ms_ahi = addr_hi; ms_ad = ad_in;
    end
    mvalid = 1;
  end

  always @(negedge clk) begin
    if (mvalid && !rst) begin
      chk("R5 ad_oe vs model", {7'd0, ad_oe}, {7'd0, exp_oe});
      chk("R5 ad_out vs model", ad_out, exp_out);
      chk("R9 irq_n vs model", {7'd0, irq_n}, {7'd0, exp_irq});
    end
  end

  // ---------------- bus tasks ----------------
  logic cur_mux = 0, cur_bts = 0;

  function automatic logic idle_ds();
    return cur_bts ? cur_mux : 1'b1;
  endfunction

  task automatic set_mode(input logic m, input logic t);
    @(negedge clk);
    cur_mux = m; cur_bts = t;
    mux_sel = m; bus_type = t;
    cs_n = 1; wr_rw = 1; rd_ds = idle_ds(); ale_a7 = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_op(input logic is_wr, input logic cs_on, input logic [1:0] bank,
                        input logic [7:0] off, input logic [7:0] wd, output logic [7:0] rdv);
    @(negedge clk);
    if (cur_mux) begin
      ad_in = off; ale_a7 = 1; addr_lo = 7'h55;
      repeat (2) @(negedge clk);
      ale_a7 = 0;
      @(negedge clk);
    end else begin
      ale_a7 = off[7]; addr_lo = off[6:0];
    end
    addr_hi = bank;
    ad_in = is_wr ? wd : 8'h3C;
    cs_n = !cs_on;
    if (cur_bts) begin
      wr_rw = !is_wr;
      @(negedge clk);
      rd_ds = !cur_mux;
    end else begin
      if (is_wr) wr_rw = 0; else rd_ds = 0;
    end
    repeat (3) @(negedge clk);
    rdv = ad_out;
    rd_ds = idle_ds();
    if (!cur_bts) wr_rw = 1;
    @(negedge clk);
    cs_n = 1; wr_rw = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] b, input logic [7:0] o, input logic [7:0] d);
    logic [7:0] dummy;
    bus_op(1, 1, b, o, d, dummy);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] b, input logic [7:0] o,
                        input logic [7:0] exp);
    logic [7:0] v;
    bus_op(0, 1, b, o, 8'h00, v);
    chk(tag, v, exp);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    chk("R12 ad_oe in reset", {7'd0, ad_oe}, 8'h00);
    chk("R12 irq_n in reset", {7'd0, irq_n}, 8'h01);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R12 ad_out after reset", ad_out, 8'h00);
    rd_chk("R12 cfg cleared", 2'd0, 8'h03, 8'h00);

    for (int m = 0; m < 4; m++) begin
      set_mode(m[0], m[1]);
      for (int b = 0; b < 4; b++) wr(2'(b), 8'h03, 8'(8'h40 + m*16 + b));
      for (int b = 0; b < 4; b++)
        rd_chk("R1 R3 R4 per-flavour bank readback", 2'(b), 8'h03, 8'(8'h40 + m*16 + b));
      wr(2'd1, 8'h0F, 8'(8'hC0 + m));
      rd_chk("R2 R4 top cfg offset", 2'd1, 8'h0F, 8'(8'hC0 + m));
      rd_chk("R2 R7 ID via offset bit 7", 2'd3, 8'h82, 8'hA5);
    end

    set_mode(1, 0);
    rd_chk("R7 revision byte", 2'd2, 8'h83, 8'h03);
    wr(2'd2, 8'h82, 8'h00);
    rd_chk("R7 ID write ignored", 2'd2, 8'h82, 8'hA5);
    wr(2'd0, 8'h40, 8'h77);
    rd_chk("R6 unmapped reads zero", 2'd0, 8'h40, 8'h00);
    wr(2'd0, 8'h10, 8'h66);
    rd_chk("R6 first offset past cfg", 2'd0, 8'h10, 8'h00);

    set_mode(0, 1);
    begin
      logic [7:0] dummy;
      bus_op(1, 0, 2'd0, 8'h03, 8'hEE, dummy);
      chk("R11 no oe without select", {7'd0, ad_oe}, 8'h00);
    end
    rd_chk("R11 unselected write ignored", 2'd0, 8'h03, 8'h70);

    @(negedge clk); stat_evt[2*8+3] = 1;
    @(negedge clk); stat_evt[2*8+3] = 0;
    rd_chk("R8 event latched", 2'd2, 8'h80, 8'h08);
    chk("R9 masked event no irq", {7'd0, irq_n}, 8'h01);
    wr(2'd2, 8'h81, 8'h08);
    @(negedge clk);
    chk("R9 enabled event irq", {7'd0, irq_n}, 8'h00);
    wr(2'd2, 8'h80, 8'h01);
    rd_chk("R8 clear of other bit keeps event", 2'd2, 8'h80, 8'h08);
    wr(2'd2, 8'h80, 8'h08);
    rd_chk("R8 write-one clears", 2'd2, 8'h80, 8'h00);
    chk("R9 irq released", {7'd0, irq_n}, 8'h01);

    wr(2'd1, 8'h02, 8'h5A);
    wr(2'd1, 8'h81, 8'hFF);
    @(negedge clk); hw_reset = 1;
    repeat (3) @(negedge clk);
    rd_chk("R10 cfg cleared by pin", 2'd1, 8'h02, 8'h00);
    rd_chk("R10 mask cleared by pin", 2'd1, 8'h81, 8'h00);
    rd_chk("R10 other bank cleared", 2'd3, 8'h03, 8'h00);
    wr(2'd1, 8'h02, 8'h99);
    rd_chk("R10 writes work with pin high", 2'd1, 8'h02, 8'h99);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    errors++;
    $display("FAIL R12 watchdog: actual running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule